// File: doc/BRIEF.md
# Addressable LED Bit Encoder

The encoder turns 24-bit pixel words into the one-wire pulse-width code that chained RGB LED strings expect. A four-word input queue takes words over a valid/ready handshake. Its not-full flag is also the data-request line for an upstream mover. Each data bit is sent as a slot of exactly ten divider ticks. The line is low for the first three ticks and high for the next two. For the last five ticks the line is high for a one and low for a zero.

A fractional divider sets the tick rate. Its period is a 16-bit whole part plus an 8-bit fraction, in system clocks. At an 8 MHz tick one slot lasts 1.25 µs. The serializer shifts each word most significant bit first. After the 24th bit it takes the next queued word with no gap. When the queue is empty at a word boundary, the line rests low until a word arrives. That low stretch is the latch gap between frames.

Top module: `led_bit_encoder`

## Requirements
- R1: After reset `line_o` is low and `req_o` is high.
- R2: Inside a continuous stream, rising edges of `line_o` are exactly 10 tick periods apart. The line changes only in the cycle after a tick.
- R3: A 1 bit holds `line_o` high for 7 consecutive ticks.
- R4: A 0 bit holds `line_o` high for 2 consecutive ticks.
- R5: Bits leave the word most significant bit first, 24 per word. A queued next word begins in the slot right after bit 0 of the current word.
- R6: With the queue empty at a word boundary, `line_o` stays low. The next accepted word then starts a new slot. No word is taken from an empty queue.
- R7: The queue holds 4 words. `req_o` is low exactly while it is full. A word offered while `req_o` is low is dropped and never appears on the line.
- R8: The tick period is `div_int_i + div_frac_i/256` clocks, and a whole part of 0 counts as 1. For example, 2.5 gives a 25-clock slot and 3.0 gives a 30-clock slot with 6-clock zero pulses and 21-clock one pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_int_i | input | 16 | Whole part of the tick period, in clocks |
| div_frac_i | input | 8 | Fractional part of the tick period, in 1/256 clocks |
| word_i | input | 24 | Pixel word; bit 23 is sent first |
| word_valid_i | input | 1 | `word_i` is offered this cycle |
| req_o | output | 1 | Queue not full: word accepted when high together with `word_valid_i` |
| line_o | output | 1 | Encoded serial data line |

## Verification
The assertions assume the divider setting is stable while a stream is in flight. They also assume `word_valid_i` is only taken to mean a transfer when `req_o` is high. The bench changes the divider only while the line is idle and the queue is empty. It counts a word as sent only when `req_o` was high at the clock edge. While the queue is full it holds a marker word on the input. That word would be decoded if the encoder ever took it.

// File: rtl/led_enc_pkg.sv
package led_enc_pkg;
  localparam int unsigned WORD_W     = 24;
  localparam int unsigned SLOT_TICKS = 10;
  localparam int unsigned LOW_TICKS  = 3;
  localparam int unsigned HIGH_TICKS = 2;
  localparam int unsigned Q_DEPTH    = 4;
  localparam int unsigned INT_W      = 16;
  localparam int unsigned FRAC_W     = 8;

  typedef enum logic {ENC_IDLE, ENC_SLOT} enc_state_e;
endpackage

// File: rtl/led_tick_div.sv
module led_tick_div #(
  parameter int unsigned INT_W  = 16,
  parameter int unsigned FRAC_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [INT_W-1:0]  div_int_i,
  input  logic [FRAC_W-1:0] div_frac_i,
  output logic              tick_o
);
  localparam int unsigned AW = INT_W + FRAC_W + 1;
  localparam logic [AW-1:0] ONE = AW'(1) << FRAC_W;

  logic [AW-1:0] acc_q, nxt, per;

  always_comb begin
    per = (div_int_i == '0) ? ONE : {1'b0, div_int_i, div_frac_i};
    nxt = acc_q + ONE;
    tick_o = (nxt >= per);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= tick_o ? nxt - per : nxt;
  end
endmodule

// File: rtl/led_word_q.sv
module led_word_q #(
  parameter int unsigned W     = 24,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  wdata_i,
  input  logic          push_i,
  input  logic          pop_i,
  output logic [W-1:0]  rdata_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [CW-1:0] fill_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign fill_o  = cnt_q;
  assign rdata_o = mem_q[rp_q];
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= bump(wp_q);
      if (do_pop)  rp_q <= bump(rp_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (do_push && wp_q == AW'(g)) mem_q[g] <= wdata_i;
    end
  end
endmodule

// File: rtl/led_slot_ser.sv
module led_slot_ser
  import led_enc_pkg::*;
#(
  parameter int unsigned W     = 24,
  parameter int unsigned SLOT  = 10,
  parameter int unsigned LOW   = 3,
  parameter int unsigned HIGH  = 2,
  localparam int unsigned CNTW = $clog2(SLOT),
  localparam int unsigned IDXW = $clog2(W)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         empty_i,
  input  logic [W-1:0] data_i,
  output logic         pop_o,
  output logic         line_o
);
  enc_state_e      st_q;
  logic [CNTW-1:0] cnt_q;
  logic [IDXW-1:0] idx_q;
  logic [W-1:0]    sh_q;
  logic            slot_end, word_end;

  assign slot_end = (cnt_q == CNTW'(SLOT - 1));
  assign word_end = slot_end && (idx_q == IDXW'(W - 1));
  assign pop_o    = tick_i && !empty_i && ((st_q == ENC_IDLE) || (st_q == ENC_SLOT && word_end));

  // low lead-in, fixed high, then value-dependent tail
  assign line_o = (st_q == ENC_SLOT) && (cnt_q >= CNTW'(LOW)) &&
                  ((cnt_q < CNTW'(LOW + HIGH)) || sh_q[W-1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ENC_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      sh_q  <= '0;
    end else if (tick_i) begin
      if (pop_o) begin
        st_q  <= ENC_SLOT;
        sh_q  <= data_i;
        idx_q <= '0;
        cnt_q <= '0;
      end else if (st_q == ENC_SLOT) begin
        if (word_end) begin
          st_q  <= ENC_IDLE;
          cnt_q <= '0;
        end else if (slot_end) begin
          sh_q  <= sh_q << 1;
          idx_q <= idx_q + 1'b1;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/led_bit_encoder.sv
module led_bit_encoder
  import led_enc_pkg::*;
#(
  parameter int unsigned W      = WORD_W,
  parameter int unsigned DEPTH  = Q_DEPTH,
  parameter int unsigned DIV_IW = INT_W,
  parameter int unsigned DIV_FW = FRAC_W,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_IW-1:0] div_int_i,
  input  logic [DIV_FW-1:0] div_frac_i,
  input  logic [W-1:0]      word_i,
  input  logic              word_valid_i,
  output logic              req_o,
  output logic              line_o
);
  logic          tick, pop, empty, full;
  logic [W-1:0]  head;
  logic [CW-1:0] fill;

  led_tick_div #(.INT_W(DIV_IW), .FRAC_W(DIV_FW)) u_div (
    .clk_i, .rst_ni, .div_int_i, .div_frac_i, .tick_o(tick)
  );

  led_word_q #(.W(W), .DEPTH(DEPTH)) u_q (
    .clk_i, .rst_ni,
    .wdata_i(word_i), .push_i(word_valid_i), .pop_i(pop),
    .rdata_o(head), .empty_o(empty), .full_o(full), .fill_o(fill)
  );

  led_slot_ser #(.W(W), .SLOT(SLOT_TICKS), .LOW(LOW_TICKS), .HIGH(HIGH_TICKS)) u_ser (
    .clk_i, .rst_ni, .tick_i(tick), .empty_i(empty), .data_i(head),
    .pop_o(pop), .line_o
  );

  assign req_o = !full;
endmodule

// File: rtl/led_enc_chk.sv
module led_enc_chk #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick_i,
  input logic          pop_i,
  input logic          empty_i,
  input logic [CW-1:0] fill_i,
  input logic          req_i,
  input logic          line_i
);
  // R7
  full_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i == CW'(DEPTH)) |-> !req_i);
  // R7
  fill_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i <= CW'(DEPTH));
  // R6
  pop_nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_i);
  // R2
  pop_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> tick_i);
  // R2
  line_tick_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(line_i));
endmodule

bind led_bit_encoder led_enc_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .pop_i(pop),
  .empty_i(empty), .fill_i(fill), .req_i(req_o), .line_i(line_o)
);

// File: tb/sim_led_bit_encoder.sv
module sim_led_bit_encoder;
  logic        clk = 0, rst_n = 0;
  logic [15:0] div_int = 16'd1;
  logic [7:0]  div_frac = 8'd0;
  logic [23:0] word = '0;
  logic        valid = 0;
  logic        req, line;

  led_bit_encoder u0 (
    .clk_i(clk), .rst_ni(rst_n), .div_int_i(div_int), .div_frac_i(div_frac),
    .word_i(word), .word_valid_i(valid), .req_o(req), .line_o(line)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  // monitor state
  int cyc = 0, hrun = 0, last_rise = -1;
  bit prev = 0;
  int slot_len = 10, thr = 5, exp_one = 7, exp_zero = 2;
  bit exact_gap = 1;
  bit got_bits [4096];
  int got_n = 0;
  bit exp_bits [4096];
  int exp_n = 0;

  task automatic check(string req_s, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d exp %0d", req_s, got, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (line) begin
      if (!prev) begin
        if (last_rise >= 0) begin
          if (exact_gap) check("R2 slot gap", cyc - last_rise, slot_len);
          else check("R2 min gap", int'(cyc - last_rise >= slot_len), 1);
        end
        last_rise = cyc;
      end
      hrun++;
    end else if (prev) begin
      if (hrun < thr) begin
        if (exp_zero > 0) check("R4 zero high", hrun, exp_zero);
        got_bits[got_n] = 1'b0;
      end else begin
        if (exp_one > 0) check("R3 one high", hrun, exp_one);
        got_bits[got_n] = 1'b1;
      end
      got_n++;
      hrun = 0;
    end
    prev = line;
  end

  task automatic begin_test(int s, int t, int o, int z, bit ex);
    slot_len = s; thr = t; exp_one = o; exp_zero = z; exact_gap = ex;
    last_rise = -1; got_n = 0; exp_n = 0;
  endtask

  // drive at negedge, accept if req high before the edge
  task automatic offer(logic [23:0] w, output bit took);
    @(negedge clk);
    word = w; valid = 1;
    took = req;
    @(posedge clk);
    @(negedge clk);
    valid = 0;
    if (took)
      for (int i = 23; i >= 0; i--) begin exp_bits[exp_n] = w[i]; exp_n++; end
  endtask

  task automatic compare(string req_s);
    check({req_s, " bit count"}, got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++)
      check({req_s, " bit"}, int'(got_bits[i]), int'(exp_bits[i]));
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 line reset", int'(line), 0);
    check("R1 req reset", int'(req), 1);
    rst_n = 1;
    wait_cyc(20);
    check("R1 line idle", int'(line), 0);
  endtask

  // R5 R3 R4: back-to-back words, MSB first, no gap between words
  task automatic t_patterns;
    logic [23:0] pats [4] = '{24'hA5F00F, 24'h000001, 24'hFFFFFE, 24'h800000};
    bit took;
    begin_test(10, 5, 7, 2, 1);
    foreach (pats[i]) begin
      offer(pats[i], took);
      check("R5 accepted", int'(took), 1);
    end
    wait_cyc(4 * 24 * 10 + 40);
    compare("R5");
  endtask

  // R7: fill queue, offered marker while full must be dropped
  task automatic t_fill;
    bit took;
    int acc = 0;
    begin_test(10, 5, 7, 2, 1);
    for (int i = 0; i < 5; i++) begin
      offer(24'h3C0000 + 24'(i), took);
      if (took) acc++;
    end
    check("R7 words taken", acc, 5);
    check("R7 req low full", int'(req), 0);
    @(negedge clk);
    word = 24'hDEAD55; valid = 1;
    wait_cyc(5);
    check("R7 req still low", int'(req), 0);
    valid = 0;
    wait_cyc(5 * 24 * 10 + 40);
    check("R7 req high drained", int'(req), 1);
    compare("R7");
  endtask

  // R6: empty queue keeps line low, later word starts clean
  task automatic t_stall;
    bit took;
    int highs = 0;
    begin_test(10, 5, 7, 2, 0);
    offer(24'h5A5A5A, took);
    wait_cyc(24 * 10 + 10);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (line) highs++;
    end
    check("R6 idle low", highs, 0);
    offer(24'hC30001, took);
    wait_cyc(24 * 10 + 40);
    compare("R6");
  endtask

  // R8: fractional and integer divider settings
  task automatic t_div(int di, int df, int slot, int t, int o, int z, string tag);
    bit took;
    @(negedge clk);
    div_int = 16'(di); div_frac = 8'(df);
    wait_cyc(10);
    begin_test(slot, t, o, z, 1);
    offer(24'hF0A50F, took);
    offer(24'h0F5AF0, took);
    wait_cyc(2 * 24 * slot + 100);
    compare(tag);
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_patterns();
    t_fill();
    t_stall();
    t_div(2, 128, 25, 12, 0, 5, "R8 2.5");
    t_div(3, 0, 30, 15, 21, 6, "R8 3.0");
    t_div(0, 0, 10, 5, 7, 2, "R8 zero-int");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule